// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a 16-bit voltage-output converter that takes its code over a serial line. Bits arrive most significant first on a data pin and move into an input shift register, one bit per enabled clock edge. A separate holding latch keeps the code that drives the converter. Shift data into several of these blocks first, then update all of their latches together, and all of their outputs change at the same moment.

Two active-low enables decide what a clock edge does: shift only, load the latch only, nothing, or both. When both are asserted, the latch takes the freshly shifted word on the same edge, so the output follows every incoming bit. The top bit of the input register is driven out on a serial output, so several blocks can be chained and written with a 16·N-bit stream. An active-low clear forces both registers to the two's-complement midscale code 0000h without waiting for a clock edge. The clear is released in step with the clock. Besides the latched two's-complement code, the block gives an offset-binary copy of it for a unipolar converter model.

Top module: `sdac_frontend`

## Requirements
- R1: With shift_en_n low and load_en_n high, a rising clk edge moves the input register left by one bit and places ser_in in bit 0, so a word entered over 16 edges arrives most significant bit first. The latch does not change.
- R2: With shift_en_n high and load_en_n low, a rising clk edge copies the input register into dac_code. The input register and ser_out do not change.
- R3: With both enables high, a rising clk edge changes neither dac_code nor ser_out, whatever ser_in is.
- R4: With both enables low, a rising clk edge shifts ser_in in, and on that same edge dac_code takes the newly shifted word.
- R5: While clr_n is low, dac_code reads 0000h, dac_code_ob reads 8000h and ser_out reads 0. Clearing takes effect at once without a clock edge and overrides every other input.
- R6: After clr_n returns high, the first two rising clk edges have no effect. The third edge is the first that acts on the enables.
- R7: ser_out is always bit 15 of the input register and changes only on edges where shifting is enabled. After a word W has been shifted in, the next 16 shift edges present W[15] down to W[0] on ser_out, which allows chaining.
- R8: dac_code_ob equals dac_code with bit 15 inverted. So 7FFFh (positive full scale) gives FFFFh, 8000h (negative full scale) gives 0000h, and 0000h (bipolar zero) gives 8000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all updates on its rising edge |
| clr_n | input | 1 | Active-low clear to midscale, asynchronous assert |
| shift_en_n | input | 1 | Active-low enable for the input shift register |
| load_en_n | input | 1 | Active-low enable for the output latch |
| ser_in | input | 1 | Serial data in, most significant bit first |
| ser_out | output | 1 | Top bit of the input register, for chaining |
| dac_code | output | 16 | Latched two's-complement code |
| dac_code_ob | output | 16 | Offset-binary form of the latched code |

## Verification
Shift, load, hold and combined operations are driven at a falling edge. Their effect on dac_code, dac_code_ob and ser_out is due at the next falling edge, after exactly one rising edge, because every output comes straight from a register or a single inverter. The driver tags each expected result with the cycle it is due, and the monitor compares it only when that cycle has been reached. Clear is different: it is checked a fraction of a period after clr_n falls, with no edge in between. After release, the two edges that must be ignored are queued with unchanged expectations, and the third edge is queued with the updated one.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   // bit 1: latch load requested, bit 0: shift requested
   typedef enum logic [1:0] {
      OP_HOLD  = 2'b00,
      OP_SHIFT = 2'b01,
      OP_LOAD  = 2'b10,
      OP_BOTH  = 2'b11
   } sdac_op_e;

   function automatic sdac_op_e decode_op(input logic shift_n, input logic load_n);
      return sdac_op_e'({~load_n, ~shift_n});
   endfunction

endpackage

// File: rtl/sdac_clr_sync.sv
module sdac_clr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   output logic rst_n
);
   generate
      if (STAGES > 8) begin : g_bad_stages
         $error("sdac_clr_sync: STAGES must not exceed 8");
      end
      if (STAGES == 0) begin : g_direct
         assign rst_n = clr_n;
      end else begin : g_chain
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) sync_q <= '0;
            else if (STAGES == 1) sync_q <= '1;
            else sync_q <= {sync_q[STAGES-2:0], 1'b1} | {STAGES{1'b0}};
         end
         assign rst_n = sync_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         ser_in,
   output logic [W-1:0] word_q,
   output logic [W-1:0] word_d,
   output logic         ser_out
);
   generate
      if (W < 2) begin : g_bad_w
         $error("sdac_shifter: W must be at least 2");
      end
   endgenerate

   assign word_d  = {word_q[W-2:0], ser_in};
   assign ser_out = word_q[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (shift_en) word_q <= word_d;
   end

   // R1
   shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (word_q[W-1:1] == $past(word_q[W-2:0])) && (word_q[0] == $past(ser_in)));

   // R7
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(ser_out));
endmodule

// File: rtl/sdac_out_latch.sv
module sdac_out_latch #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic         follow,
   input  logic [W-1:0] word_q,
   input  logic [W-1:0] word_d,
   output logic [W-1:0] code_q,
   output logic [W-1:0] code_ob
);
   logic [W-1:0] load_val;

   assign load_val = follow ? word_d : word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= '0;
      else if (load_en) code_q <= load_val;
   end

   generate
      if (W < 2) begin : g_bad_w
         $error("sdac_out_latch: W must be at least 2");
      end else begin : g_ob
         assign code_ob = {~code_q[W-1], code_q[W-2:0]};
      end
   endgenerate

   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !follow) |=> code_q == $past(word_q));

   // R4
   follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && follow) |=> code_q == word_q);
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
   parameter int CODE_W          = 16,
   parameter int CLR_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              shift_en_n,
   input  logic              load_en_n,
   input  logic              ser_in,
   output logic              ser_out,
   output logic [CODE_W-1:0] dac_code,
   output logic [CODE_W-1:0] dac_code_ob
);
   import sdac_pkg::*;

   localparam int MSB = CODE_W - 1;

   generate
      if (CODE_W < 2 || CODE_W > 64) begin : g_bad_width
         $error("sdac_frontend: CODE_W out of range 2..64");
      end
   endgenerate

   logic        rst_n;
   sdac_op_e    op;
   logic        do_shift;
   logic        do_load;
   logic [MSB:0] word_q;
   logic [MSB:0] word_d;

   assign op       = decode_op(shift_en_n, load_en_n);
   assign do_shift = (op == OP_SHIFT) || (op == OP_BOTH);
   assign do_load  = (op == OP_LOAD)  || (op == OP_BOTH);

   sdac_clr_sync #(.STAGES(CLR_SYNC_STAGES)) u_sync (
      .clk   (clk),
      .clr_n (clr_n),
      .rst_n (rst_n)
   );

   sdac_shifter #(.W(CODE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (do_shift),
      .ser_in   (ser_in),
      .word_q   (word_q),
      .word_d   (word_d),
      .ser_out  (ser_out)
   );

   sdac_out_latch #(.W(CODE_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (do_load),
      .follow  (do_shift),
      .word_q  (word_q),
      .word_d  (word_d),
      .code_q  (dac_code),
      .code_ob (dac_code_ob)
   );

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_HOLD) |=> ($stable(dac_code) && $stable(ser_out)));

   // R5
   always_ff @(posedge clk) begin
      if (rst_n === 1'b0) begin
         clear_state_chk: assert (dac_code == '0 && ser_out == 1'b0);
      end
   end
endmodule

// File: tb/tb_sdac_frontend.sv
module tb_sdac_frontend;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         shift_en_n = 1'b1;
   logic         load_en_n = 1'b1;
   logic         ser_in = 1'b0;
   logic         ser_out;
   logic [W-1:0] dac_code;
   logic [W-1:0] dac_code_ob;

   always #4 clk = ~clk;

   sdac_frontend #(.CODE_W(W), .CLR_SYNC_STAGES(2)) dut (
      .clk         (clk),
      .clr_n       (clr_n),
      .shift_en_n  (shift_en_n),
      .load_en_n   (load_en_n),
      .ser_in      (ser_in),
      .ser_out     (ser_out),
      .dac_code    (dac_code),
      .dac_code_ob (dac_code_ob)
   );

   typedef struct {
      logic [W-1:0] code;
      logic         sdo;
      int           due;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   exp_t         cur;
   int           cyc = 0;
   int           checks = 0;
   int           fails = 0;
   logic [W-1:0] m_shift = '0;
   logic [W-1:0] m_latch = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] to_ob(input logic [W-1:0] c);
      return {~c[W-1], c[W-2:0]};
   endfunction

   // monitor: compare each expected item once its cycle is reached
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         cur = sb.pop_front();
         check({cur.tag, " code"}, dac_code, cur.code);
         check({cur.tag, " ser_out"}, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, cur.sdo});
         check("R8 offset-binary", dac_code_ob, to_ob(cur.code));
      end
   end

   // driver: one clock edge of stimulus, expected result pushed to the scoreboard
   task automatic step(input logic a_sh_n, input logic a_ld_n, input logic d,
                       input bit live, input string tag);
      logic [W-1:0] nxt;
      exp_t e;
      @(negedge clk);
      shift_en_n = a_sh_n;
      load_en_n  = a_ld_n;
      ser_in     = d;
      if (live) begin
         nxt = a_sh_n ? m_shift : {m_shift[W-2:0], d};
         if (!a_ld_n) m_latch = nxt;
         m_shift = nxt;
      end
      e.code = m_latch;
      e.sdo  = m_shift[W-1];
      e.due  = cyc + 1;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic shift_word(input logic [W-1:0] w, input string tag);
      for (int i = W - 1; i >= 0; i--) step(1'b0, 1'b1, w[i], 1'b1, tag);
   endtask

   task automatic clear_and_release();
      @(negedge clk);
      @(negedge clk);
      @(posedge clk);
      #2;
      shift_en_n = 1'b0;
      load_en_n  = 1'b0;
      ser_in     = 1'b1;
      clr_n      = 1'b0;
      #1;
      // R5: immediate effect, no clock edge since clr_n fell
      check("R5 code async", dac_code, '0);
      check("R5 ob async", dac_code_ob, 16'h8000);
      check("R5 ser_out async", {{(W-1){1'b0}}, ser_out}, '0);
      m_shift = '0;
      m_latch = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R5 code held", dac_code, '0);
      #1;
      clr_n = 1'b1;
      // R6: two edges ignored, the third acts
      step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ignored");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ignored");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R6 first");
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R5 reset code", dac_code, '0);
      check("R5 reset ob", dac_code_ob, 16'h8000);
      check("R5 reset ser_out", {{(W-1){1'b0}}, ser_out}, '0);
      @(posedge clk);
      #2;
      clr_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ignored");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ignored");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R6 first");

      // positive full scale
      shift_word(16'h7FFF, "R1 shift");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R2 load");
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, i[0], 1'b1, "R3 hold");

      // negative full scale
      shift_word(16'h8000, "R1 shift");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "R3 hold");
      step(1'b1, 1'b0, 1'b1, 1'b1, "R2 load");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R2 reload");

      // chaining: second word pushes the first out MSB first
      shift_word(16'hA5C3, "R1 shift");
      shift_word(16'h1234, "R7 chain");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R2 load");

      // bipolar zero
      shift_word(16'h0000, "R1 shift");
      step(1'b1, 1'b0, 1'b1, 1'b1, "R2 load");

      // combined mode: output follows each bit
      for (int i = 0; i < 20; i++) step(1'b0, 1'b0, ((i * 7 + 3) % 5) < 2, 1'b1, "R4 both");
      step(1'b1, 1'b1, 1'b0, 1'b1, "R3 hold");

      // clear in the middle of a stream
      shift_word(16'h3C0F, "R1 shift");
      clear_and_release();
      shift_word(16'hF00D, "R1 shift");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R2 load");
      step(1'b1, 1'b1, 1'b1, 1'b1, "R3 hold");

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R1 scoreboard: actual=%0d expected=0", sb.size());
      end
      report();
      $finish;
   end
endmodule